// File: doc/BRIEF.md
# Per-Stream Time-Window Ingress Policer

This block makes the admission decision for each incoming frame descriptor. A descriptor carries a destination MAC, a VLAN ID, a PCP value, a frame length and an arrival timestamp. The block searches a small stream table for an entry whose key equals the {destination MAC, VLAN ID, PCP} triple. If no entry matches, the frame is passed on to normal forwarding. If an entry matches, the frame has to meet that entry's rules, and the block returns the entry's explicit destination port set and trap-to-CPU flag in place of a learned destination.

A matched entry can drop a frame for three reasons. The first applies only to a gated entry: the arrival time falls in the closed part of the entry's cyclic open/close window. The second is an empty destination set. The third is a length above the entry's maximum. Each dropped frame adds one to a saturating frame counter kept for that entry. Software can read the counter and clear it through an index port.

Timestamps and window parameters count 200 ns slots. These are the slots used by the egress gate schedule, so a window edge always falls on a slot edge. The stream table is loaded from configuration inputs. It can hold up to 1024 entries, and the depth is a parameter that defaults to 8.

Top module: `stream_gate_policer`

## Requirements
- R1: After reset every table entry is invalid, every drop counter reads 0, and out_valid, out_hit, out_pass, out_idx, out_ports, out_trap and out_cause are all 0.
- R2: A frame matches an entry only when the entry is valid and the destination MAC, the VLAN ID and the PCP are all equal to the entry's key. If several entries match, the entry with the lowest index is used, and its index appears on out_idx.
- R3: An unmatched frame produces out_hit=0, out_pass=1, out_cause=0, out_idx=0, out_ports=0 and out_trap=0, and it changes no drop counter.
- R4: For a gated entry, the window is open at timestamp t only when open_len is non-zero, t >= base, and (t - base) mod (open_len + close_len) < open_len. A frame that arrives while the window is closed is dropped. A frame that arrives before the base time is also dropped.
- R5: For a matched entry that is not gated, the timestamp has no effect on the decision.
- R6: A matched frame is dropped when its entry has an all-zero port bitmap and its trap bit is clear. If the trap bit is set, an empty bitmap does not cause a drop.
- R7: A matched frame is dropped when its length is strictly greater than the entry's maximum length. A length equal to the maximum is accepted.
- R8: out_cause uses these codes: 0 for passed, 1 for window closed, 2 for empty destination, 3 for over-length. When several checks fail, the lowest non-zero code is reported. A frame with a non-zero cause has out_pass=0.
- R9: Each dropped matched frame adds one to the counter of the matched entry. The counter stops at 2^CNT_W-1, which is 255 with the defaults. cnt_val combinationally shows the counter selected by cnt_idx.
- R10: A pulse on cnt_clr sets the counter selected by cnt_idx to 0. A clear wins over an increment of the same counter in the same cycle.
- R11: The decision appears on the out_* ports in the cycle after the frame is presented. out_valid is 1 exactly one cycle after each frm_valid cycle, and back-to-back frames are allowed. A table write takes effect for frames presented from the next cycle, so a frame in the same cycle as the write sees the old entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Table entry write strobe |
| cfg_idx | input | IDX_W | Index of the entry to write |
| cfg_valid | input | 1 | Entry valid bit |
| cfg_dmac | input | 48 | Key: destination MAC |
| cfg_vid | input | 12 | Key: VLAN ID |
| cfg_pcp | input | 3 | Key: PCP |
| cfg_ports | input | NPORTS | Destination port bitmap |
| cfg_trap | input | 1 | Trap-to-CPU bit |
| cfg_maxlen | input | LEN_W | Maximum accepted frame length |
| cfg_gated | input | 1 | Enables the time-window check |
| cfg_base | input | TS_W | Window base time, in slots |
| cfg_open | input | WIN_W | Open interval, in slots |
| cfg_close | input | WIN_W | Closed interval, in slots |
| frm_valid | input | 1 | Frame descriptor present |
| frm_dmac | input | 48 | Frame destination MAC |
| frm_vid | input | 12 | Frame VLAN ID |
| frm_pcp | input | 3 | Frame PCP |
| frm_len | input | LEN_W | Frame length |
| frm_ts | input | TS_W | Arrival time, in slots |
| cnt_clr | input | 1 | Clears the counter selected by cnt_idx |
| cnt_idx | input | IDX_W | Counter select, for both reading and clearing |
| out_valid | output | 1 | Decision valid |
| out_hit | output | 1 | A stream entry matched |
| out_pass | output | 1 | Frame admitted |
| out_idx | output | IDX_W | Matched entry index |
| out_ports | output | NPORTS | Destination bitmap of the matched entry |
| out_trap | output | 1 | Trap bit of the matched entry |
| out_cause | output | 2 | Drop cause code |
| cnt_val | output | CNT_W | Value of the selected drop counter |

## Verification
The key lookup is tried with frames that differ from a stored key in only one field: MAC, VID or PCP. This exposes a comparator that leaves out a field. Two entries with the same key check that the lower index wins. The window is probed at timestamps one slot before and at each open and close edge, before the base time, and several periods later. These probes expose off-by-one edges, wrong modulo handling and a missing base check. Frames that fail several checks at once check the cause priority. A long run of drops followed by clears, one of them in the same cycle as an increment, checks saturation and that the clear wins.

// File: rtl/sgp_pkg.sv
package sgp_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE   = 2'd0,
    CAUSE_WINDOW = 2'd1,
    CAUSE_NODEST = 2'd2,
    CAUSE_LENGTH = 2'd3
  } cause_e;

  localparam int MAC_W = 48;
  localparam int VID_W = 12;
  localparam int PCP_W = 3;
endpackage

// File: rtl/sgp_stream_lookup.sv
module sgp_stream_lookup
  import sgp_pkg::*;
#(
  parameter int NSTREAMS = 8,
  parameter int NPORTS   = 5,
  parameter int TS_W     = 32,
  parameter int WIN_W    = 16,
  parameter int LEN_W    = 14,
  localparam int IDX_W   = $clog2(NSTREAMS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_valid,
  input  logic [MAC_W-1:0]  wr_dmac,
  input  logic [VID_W-1:0]  wr_vid,
  input  logic [PCP_W-1:0]  wr_pcp,
  input  logic [NPORTS-1:0] wr_ports,
  input  logic              wr_trap,
  input  logic [LEN_W-1:0]  wr_maxlen,
  input  logic              wr_gated,
  input  logic [TS_W-1:0]   wr_base,
  input  logic [WIN_W-1:0]  wr_open,
  input  logic [WIN_W-1:0]  wr_close,
  input  logic [MAC_W-1:0]  key_dmac,
  input  logic [VID_W-1:0]  key_vid,
  input  logic [PCP_W-1:0]  key_pcp,
  output logic              hit,
  output logic [IDX_W-1:0]  sel,
  output logic [NPORTS-1:0] sel_ports,
  output logic              sel_trap,
  output logic [LEN_W-1:0]  sel_maxlen,
  output logic              sel_gated,
  output logic [TS_W-1:0]   sel_base,
  output logic [WIN_W-1:0]  sel_open,
  output logic [WIN_W-1:0]  sel_close
);
  logic              t_valid  [NSTREAMS];
  logic [MAC_W-1:0]  t_dmac   [NSTREAMS];
  logic [VID_W-1:0]  t_vid    [NSTREAMS];
  logic [PCP_W-1:0]  t_pcp    [NSTREAMS];
  logic [NPORTS-1:0] t_ports  [NSTREAMS];
  logic              t_trap   [NSTREAMS];
  logic [LEN_W-1:0]  t_maxlen [NSTREAMS];
  logic              t_gated  [NSTREAMS];
  logic [TS_W-1:0]   t_base   [NSTREAMS];
  logic [WIN_W-1:0]  t_open   [NSTREAMS];
  logic [WIN_W-1:0]  t_close  [NSTREAMS];
  logic [NSTREAMS-1:0] match_vec;

  for (genvar g = 0; g < NSTREAMS; g++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        t_valid[g]  <= 1'b0;
        t_dmac[g]   <= '0;
        t_vid[g]    <= '0;
        t_pcp[g]    <= '0;
        t_ports[g]  <= '0;
        t_trap[g]   <= 1'b0;
        t_maxlen[g] <= '0;
        t_gated[g]  <= 1'b0;
        t_base[g]   <= '0;
        t_open[g]   <= '0;
        t_close[g]  <= '0;
      end else if (wr_en && wr_idx == IDX_W'(g)) begin
        t_valid[g]  <= wr_valid;
        t_dmac[g]   <= wr_dmac;
        t_vid[g]    <= wr_vid;
        t_pcp[g]    <= wr_pcp;
        t_ports[g]  <= wr_ports;
        t_trap[g]   <= wr_trap;
        t_maxlen[g] <= wr_maxlen;
        t_gated[g]  <= wr_gated;
        t_base[g]   <= wr_base;
        t_open[g]   <= wr_open;
        t_close[g]  <= wr_close;
      end
    end

    assign match_vec[g] = t_valid[g] && (t_dmac[g] == key_dmac) &&
                          (t_vid[g] == key_vid) && (t_pcp[g] == key_pcp);
  end

  always_comb begin
    sel = '0;
    for (int i = NSTREAMS - 1; i >= 0; i--) begin
      if (match_vec[i]) sel = IDX_W'(i);
    end
  end

  assign hit        = |match_vec;
  assign sel_ports  = t_ports[sel];
  assign sel_trap   = t_trap[sel];
  assign sel_maxlen = t_maxlen[sel];
  assign sel_gated  = t_gated[sel];
  assign sel_base   = t_base[sel];
  assign sel_open   = t_open[sel];
  assign sel_close  = t_close[sel];
endmodule

// File: rtl/sgp_window_eval.sv
module sgp_window_eval #(
  parameter int TS_W  = 32,
  parameter int WIN_W = 16
) (
  input  logic [TS_W-1:0]  ts,
  input  logic [TS_W-1:0]  base,
  input  logic [WIN_W-1:0] open_len,
  input  logic [WIN_W-1:0] close_len,
  output logic             is_open
);
  function automatic logic window_open(input logic [TS_W-1:0]  t,
                                       input logic [TS_W-1:0]  b,
                                       input logic [WIN_W-1:0] op,
                                       input logic [WIN_W-1:0] cl);
    logic [WIN_W:0]  period;
    logic [TS_W-1:0] elapsed;
    logic [TS_W-1:0] phase;
    period = {1'b0, op} + {1'b0, cl};
    if (op == '0 || t < b) return 1'b0;
    elapsed = t - b;
    phase   = elapsed % TS_W'(period);
    return phase < TS_W'(op);
  endfunction

  assign is_open = window_open(ts, base, open_len, close_len);
endmodule

// File: rtl/sgp_drop_counters.sv
module sgp_drop_counters #(
  parameter int NSTREAMS = 8,
  parameter int CNT_W    = 8,
  localparam int IDX_W   = $clog2(NSTREAMS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_en,
  input  logic [IDX_W-1:0] inc_idx,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] sel_idx,
  output logic [CNT_W-1:0] sel_val
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  logic [CNT_W-1:0] cnt [NSTREAMS];

  for (genvar g = 0; g < NSTREAMS; g++) begin : g_cnt
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        cnt[g] <= '0;
      else if (clr_en && sel_idx == IDX_W'(g))
        cnt[g] <= '0;
      else if (inc_en && inc_idx == IDX_W'(g) && cnt[g] != CNT_MAX)
        cnt[g] <= cnt[g] + 1'b1;
    end
  end

  assign sel_val = cnt[sel_idx];
endmodule

// File: rtl/stream_gate_policer.sv
module stream_gate_policer
  import sgp_pkg::*;
#(
  parameter int NSTREAMS = 8,
  parameter int NPORTS   = 5,
  parameter int TS_W     = 32,
  parameter int WIN_W    = 16,
  parameter int LEN_W    = 14,
  parameter int CNT_W    = 8,
  localparam int IDX_W   = $clog2(NSTREAMS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic              cfg_valid,
  input  logic [47:0]       cfg_dmac,
  input  logic [11:0]       cfg_vid,
  input  logic [2:0]        cfg_pcp,
  input  logic [NPORTS-1:0] cfg_ports,
  input  logic              cfg_trap,
  input  logic [LEN_W-1:0]  cfg_maxlen,
  input  logic              cfg_gated,
  input  logic [TS_W-1:0]   cfg_base,
  input  logic [WIN_W-1:0]  cfg_open,
  input  logic [WIN_W-1:0]  cfg_close,
  input  logic              frm_valid,
  input  logic [47:0]       frm_dmac,
  input  logic [11:0]       frm_vid,
  input  logic [2:0]        frm_pcp,
  input  logic [LEN_W-1:0]  frm_len,
  input  logic [TS_W-1:0]   frm_ts,
  input  logic              cnt_clr,
  input  logic [IDX_W-1:0]  cnt_idx,
  output logic              out_valid,
  output logic              out_hit,
  output logic              out_pass,
  output logic [IDX_W-1:0]  out_idx,
  output logic [NPORTS-1:0] out_ports,
  output logic              out_trap,
  output logic [1:0]        out_cause,
  output logic [CNT_W-1:0]  cnt_val
);
  logic              lk_hit;
  logic [IDX_W-1:0]  lk_sel;
  logic [NPORTS-1:0] lk_ports;
  logic              lk_trap;
  logic [LEN_W-1:0]  lk_maxlen;
  logic              lk_gated;
  logic [TS_W-1:0]   lk_base;
  logic [WIN_W-1:0]  lk_open;
  logic [WIN_W-1:0]  lk_close;
  logic              win_is_open;
  logic              win_ok, dest_ok, len_ok;
  cause_e            cause_now;
  logic              drop_evt;

  sgp_stream_lookup #(
    .NSTREAMS(NSTREAMS), .NPORTS(NPORTS), .TS_W(TS_W),
    .WIN_W(WIN_W), .LEN_W(LEN_W)
  ) lookup_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_we), .wr_idx(cfg_idx), .wr_valid(cfg_valid),
    .wr_dmac(cfg_dmac), .wr_vid(cfg_vid), .wr_pcp(cfg_pcp),
    .wr_ports(cfg_ports), .wr_trap(cfg_trap), .wr_maxlen(cfg_maxlen),
    .wr_gated(cfg_gated), .wr_base(cfg_base), .wr_open(cfg_open),
    .wr_close(cfg_close),
    .key_dmac(frm_dmac), .key_vid(frm_vid), .key_pcp(frm_pcp),
    .hit(lk_hit), .sel(lk_sel), .sel_ports(lk_ports), .sel_trap(lk_trap),
    .sel_maxlen(lk_maxlen), .sel_gated(lk_gated), .sel_base(lk_base),
    .sel_open(lk_open), .sel_close(lk_close)
  );

  sgp_window_eval #(.TS_W(TS_W), .WIN_W(WIN_W)) window_i (
    .ts(frm_ts), .base(lk_base), .open_len(lk_open),
    .close_len(lk_close), .is_open(win_is_open)
  );

  assign win_ok  = !lk_gated || win_is_open;
  assign dest_ok = (|lk_ports) || lk_trap;
  assign len_ok  = frm_len <= lk_maxlen;

  always_comb begin
    if (!lk_hit)       cause_now = CAUSE_NONE;
    else if (!win_ok)  cause_now = CAUSE_WINDOW;
    else if (!dest_ok) cause_now = CAUSE_NODEST;
    else if (!len_ok)  cause_now = CAUSE_LENGTH;
    else               cause_now = CAUSE_NONE;
  end

  assign drop_evt = frm_valid && lk_hit && (cause_now != CAUSE_NONE);

  sgp_drop_counters #(.NSTREAMS(NSTREAMS), .CNT_W(CNT_W)) counters_i (
    .clk(clk), .rst_n(rst_n),
    .inc_en(drop_evt), .inc_idx(lk_sel),
    .clr_en(cnt_clr), .sel_idx(cnt_idx), .sel_val(cnt_val)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_hit   <= 1'b0;
      out_pass  <= 1'b0;
      out_idx   <= '0;
      out_ports <= '0;
      out_trap  <= 1'b0;
      out_cause <= '0;
    end else if (frm_valid) begin
      out_valid <= 1'b1;
      out_hit   <= lk_hit;
      out_pass  <= (cause_now == CAUSE_NONE);
      out_idx   <= lk_hit ? lk_sel : '0;
      out_ports <= lk_hit ? lk_ports : '0;
      out_trap  <= lk_hit && lk_trap;
      out_cause <= cause_now;
    end else begin
      out_valid <= 1'b0;
      out_hit   <= 1'b0;
      out_pass  <= 1'b0;
      out_idx   <= '0;
      out_ports <= '0;
      out_trap  <= 1'b0;
      out_cause <= '0;
    end
  end
endmodule

// File: rtl/sgp_checker.sv
module sgp_checker #(
  parameter int IDX_W = 3,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frm_valid,
  input logic             drop_evt,
  input logic             out_valid,
  input logic             out_hit,
  input logic             out_pass,
  input logic [1:0]       out_cause,
  input logic             cnt_clr,
  input logic [IDX_W-1:0] cnt_idx,
  input logic [CNT_W-1:0] cnt_val
);
  a_r11_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid |=> out_valid);
  a_r11_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_valid |=> !out_valid);
  a_r3_miss_passes: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_hit) |-> (out_pass && out_cause == 2'd0));
  a_r8_cause_blocks_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_cause != 2'd0) |-> !out_pass);
  a_r9_drop_reported: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |=> (out_valid && out_hit && !out_pass));
  a_r9_no_decrease: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_clr |=> (cnt_idx != $past(cnt_idx)) || (cnt_val >= $past(cnt_val)));
  a_r10_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> (cnt_idx != $past(cnt_idx)) || (cnt_val == '0));
endmodule

bind stream_gate_policer sgp_checker #(.IDX_W(IDX_W), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .drop_evt(drop_evt),
  .out_valid(out_valid), .out_hit(out_hit), .out_pass(out_pass),
  .out_cause(out_cause), .cnt_clr(cnt_clr), .cnt_idx(cnt_idx),
  .cnt_val(cnt_val)
);

// File: tb/stream_gate_policer_tb_top.sv
`timescale 1ns/1ps
module stream_gate_policer_tb_top;
  localparam int NS = 8, NP = 5, TW = 32, WW = 16, LW = 14, CW = 8, IW = 3;
  localparam int CMAX = 255;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0, cfg_valid = 0, cfg_trap = 0, cfg_gated = 0;
  logic [IW-1:0] cfg_idx = '0;
  logic [47:0] cfg_dmac = '0;
  logic [11:0] cfg_vid = '0;
  logic [2:0]  cfg_pcp = '0;
  logic [NP-1:0] cfg_ports = '0;
  logic [LW-1:0] cfg_maxlen = '0;
  logic [TW-1:0] cfg_base = '0;
  logic [WW-1:0] cfg_open = '0, cfg_close = '0;
  logic frm_valid = 0;
  logic [47:0] frm_dmac = '0;
  logic [11:0] frm_vid = '0;
  logic [2:0]  frm_pcp = '0;
  logic [LW-1:0] frm_len = '0;
  logic [TW-1:0] frm_ts = '0;
  logic cnt_clr = 0;
  logic [IW-1:0] cnt_idx = '0;
  logic out_valid, out_hit, out_pass, out_trap;
  logic [IW-1:0] out_idx;
  logic [NP-1:0] out_ports;
  logic [1:0] out_cause;
  logic [CW-1:0] cnt_val;

  int total = 0, bad = 0;
  string cur_req = "R1";
  bit done = 0;

  always #5 clk = ~clk;

  stream_gate_policer dut_i (.*);

  // reference model state
  bit          m_valid [NS];
  logic [47:0] m_dmac [NS];
  int          m_vid [NS], m_pcp [NS], m_ports [NS], m_maxlen [NS];
  bit          m_trap [NS], m_gated [NS];
  longint      m_base [NS], m_open [NS], m_close [NS];
  int          m_cnt [NS];
  int e_valid, e_hit, e_pass, e_idx, e_ports, e_trap, e_cause;

  function automatic bit ref_open(longint t, longint b, longint op, longint cl);
    if (op == 0) return 0;
    if (t < b) return 0;
    return ((t - b) % (op + cl)) < op;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_valid[i]) begin
        m_valid[i] = 0; m_cnt[i] = 0;
      end
      e_valid = 0; e_hit = 0; e_pass = 0; e_idx = 0;
      e_ports = 0; e_trap = 0; e_cause = 0;
    end else begin
      if (frm_valid) begin
        int hit_at;
        hit_at = -1;
        for (int i = 0; i < NS; i++)
          if (hit_at < 0 && m_valid[i] && m_dmac[i] == frm_dmac &&
              m_vid[i] == int'(frm_vid) && m_pcp[i] == int'(frm_pcp))
            hit_at = i;
        e_valid = 1;
        if (hit_at < 0) begin
          e_hit = 0; e_pass = 1; e_idx = 0; e_ports = 0; e_trap = 0; e_cause = 0;
        end else begin
          e_hit = 1; e_idx = hit_at; e_ports = m_ports[hit_at];
          e_trap = m_trap[hit_at];
          if (m_gated[hit_at] && !ref_open(longint'(frm_ts), m_base[hit_at],
                                           m_open[hit_at], m_close[hit_at]))
            e_cause = 1;
          else if (m_ports[hit_at] == 0 && !m_trap[hit_at]) e_cause = 2;
          else if (int'(frm_len) > m_maxlen[hit_at]) e_cause = 3;
          else e_cause = 0;
          e_pass = (e_cause == 0);
          if (e_cause != 0 && m_cnt[hit_at] < CMAX) m_cnt[hit_at]++;
        end
      end else begin
        e_valid = 0; e_hit = 0; e_pass = 0; e_idx = 0;
        e_ports = 0; e_trap = 0; e_cause = 0;
      end
      if (cnt_clr) m_cnt[cnt_idx] = 0;
      if (cfg_we) begin
        m_valid[cfg_idx] = cfg_valid; m_dmac[cfg_idx] = cfg_dmac;
        m_vid[cfg_idx] = cfg_vid; m_pcp[cfg_idx] = cfg_pcp;
        m_ports[cfg_idx] = cfg_ports; m_trap[cfg_idx] = cfg_trap;
        m_maxlen[cfg_idx] = cfg_maxlen; m_gated[cfg_idx] = cfg_gated;
        m_base[cfg_idx] = cfg_base; m_open[cfg_idx] = cfg_open;
        m_close[cfg_idx] = cfg_close;
      end
    end
  end

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      total++;
      if (int'(out_valid) != e_valid || int'(out_hit) != e_hit ||
          int'(out_pass) != e_pass || int'(out_idx) != e_idx ||
          int'(out_ports) != e_ports || int'(out_trap) != e_trap ||
          int'(out_cause) != e_cause || int'(cnt_val) != m_cnt[cnt_idx]) begin
        bad++;
        $display("FAIL %s model: act v%0d h%0d p%0d i%0d pt%0d t%0d c%0d n%0d exp v%0d h%0d p%0d i%0d pt%0d t%0d c%0d n%0d",
          cur_req, out_valid, out_hit, out_pass, out_idx, out_ports, out_trap,
          out_cause, cnt_val, e_valid, e_hit, e_pass, e_idx, e_ports, e_trap,
          e_cause, m_cnt[cnt_idx]);
      end
    end
  end

  task automatic chk(string req, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfg_write(int idx, bit v, logic [47:0] mac, int vid, int pcp,
                           int ports, bit trap, int maxlen, bit gated,
                           int base, int op, int cl);
    cfg_we = 1; cfg_idx = IW'(idx); cfg_valid = v; cfg_dmac = mac;
    cfg_vid = 12'(vid); cfg_pcp = 3'(pcp); cfg_ports = NP'(ports);
    cfg_trap = trap; cfg_maxlen = LW'(maxlen); cfg_gated = gated;
    cfg_base = TW'(base); cfg_open = WW'(op); cfg_close = WW'(cl);
    @(negedge clk); #1;
    cfg_we = 0;
  endtask

  task automatic frame(logic [47:0] mac, int vid, int pcp, int len, int ts);
    frm_valid = 1; frm_dmac = mac; frm_vid = 12'(vid); frm_pcp = 3'(pcp);
    frm_len = LW'(len); frm_ts = TW'(ts);
    @(negedge clk); #1;
    frm_valid = 0;
  endtask

  task automatic idle();
    @(negedge clk); #1;
  endtask

  task automatic read_cnt(int idx, output int v);
    cnt_idx = IW'(idx); #1; v = cnt_val;
  endtask

  localparam logic [47:0] MA = 48'h42be249b7620;
  localparam logic [47:0] MB = 48'h0011223344aa;
  localparam logic [47:0] MC = 48'h020000000001;
  localparam logic [47:0] MG = 48'h0a0b0c0d0e0f;
  localparam logic [47:0] MH = 48'h0a0b0c0d0e10;

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1; total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    int v;
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    idle();
    cur_req = "R1";
    chk("R1 out_valid", out_valid, 0);
    chk("R1 out_cause", out_cause, 0);
    for (int i = 0; i < NS; i++) begin
      read_cnt(i, v); chk("R1 counter", v, 0);
    end
    frame(48'h0, 0, 0, 64, 0);
    chk("R1 empty table miss", out_hit, 0);

    cur_req = "R2";
    cfg_write(0, 1, MA, 100, 0, 5'b00011, 0, 100, 0, 0, 0, 0);
    frame(MA, 100, 0, 64, 7);
    chk("R2 hit", out_hit, 1); chk("R2 ports", out_ports, 3);
    chk("R2 pass", out_pass, 1);
    cur_req = "R3";
    frame(MA, 101, 0, 64, 7);  chk("R3 vid miss", out_hit, 0);
    chk("R3 miss pass", out_pass, 1); chk("R3 miss ports", out_ports, 0);
    frame(MA, 100, 1, 64, 7);  chk("R3 pcp miss", out_hit, 0);
    frame(MA ^ 48'h1, 100, 0, 64, 7); chk("R3 mac miss", out_hit, 0);
    read_cnt(0, v); chk("R3 no count", v, 0);
    cur_req = "R2";
    cfg_write(3, 1, MB, 5, 2, 5'b10000, 0, 1500, 0, 0, 0, 0);
    cfg_write(1, 1, MB, 5, 2, 5'b00100, 1, 1500, 0, 0, 0, 0);
    frame(MB, 5, 2, 64, 0);
    chk("R2 lowest index", out_idx, 1); chk("R2 lowest ports", out_ports, 4);
    chk("R2 trap", out_trap, 1);

    cur_req = "R7";
    frame(MA, 100, 0, 100, 0); chk("R7 equal len pass", out_pass, 1);
    frame(MA, 100, 0, 101, 0); chk("R7 over len drop", out_cause, 3);
    read_cnt(0, v); chk("R7 counted", v, 1);

    cur_req = "R6";
    cfg_write(2, 1, MC, 7, 3, 0, 0, 1500, 0, 0, 0, 0);
    frame(MC, 7, 3, 64, 0); chk("R6 empty dest drop", out_cause, 2);
    cfg_write(6, 1, MC, 8, 3, 0, 1, 1500, 0, 0, 0, 0);
    frame(MC, 8, 3, 64, 0); chk("R6 trap only pass", out_pass, 1);

    cur_req = "R4";
    cfg_write(4, 1, MG, 10, 5, 5'b00001, 0, 1500, 1, 1000, 300, 200);
    frame(MG, 10, 5, 64, 999);  chk("R4 before base", out_cause, 1);
    frame(MG, 10, 5, 64, 1000); chk("R4 open edge", out_pass, 1);
    frame(MG, 10, 5, 64, 1299); chk("R4 last open", out_pass, 1);
    frame(MG, 10, 5, 64, 1300); chk("R4 close edge", out_cause, 1);
    frame(MG, 10, 5, 64, 1499); chk("R4 last closed", out_cause, 1);
    frame(MG, 10, 5, 64, 1500); chk("R4 reopen", out_pass, 1);
    frame(MG, 10, 5, 64, 6010); chk("R4 later period", out_pass, 1);
    frame(MG, 10, 5, 64, 6320); chk("R4 later closed", out_pass, 0);
    read_cnt(4, v); chk("R4 window drops counted", v, 4);

    cur_req = "R5";
    frame(MA, 100, 0, 64, 0);          chk("R5 ts zero", out_pass, 1);
    frame(MA, 100, 0, 64, 32'h7fffffff); chk("R5 ts large", out_pass, 1);

    cur_req = "R8";
    cfg_write(5, 1, MH, 11, 0, 0, 0, 50, 1, 0, 10, 10);
    frame(MH, 11, 0, 60, 15); chk("R8 all fail -> 1", out_cause, 1);
    chk("R8 no pass", out_pass, 0);
    frame(MH, 11, 0, 60, 25); chk("R8 dest+len -> 2", out_cause, 2);

    cur_req = "R9";
    for (int i = 0; i < 260; i++) frame(MC, 7, 3, 64, 0);
    read_cnt(2, v); chk("R9 saturate", v, CMAX);

    cur_req = "R10";
    cnt_idx = 3'd2; cnt_clr = 1; idle(); cnt_clr = 0;
    read_cnt(2, v); chk("R10 cleared", v, 0);
    frame(MC, 7, 3, 64, 0);
    read_cnt(2, v); chk("R10 counts after clear", v, 1);
    cnt_idx = 3'd2; cnt_clr = 1; frame(MC, 7, 3, 64, 0); cnt_clr = 0;
    read_cnt(2, v); chk("R10 clear wins", v, 0);

    cur_req = "R11";
    cfg_write(0, 0, MA, 100, 0, 0, 0, 0, 0, 0, 0, 0);
    frame(MA, 100, 0, 64, 0); chk("R11 invalidated", out_hit, 0);
    cfg_we = 1; cfg_idx = 3'd0; cfg_valid = 1; cfg_dmac = MA; cfg_vid = 12'd100;
    cfg_pcp = 3'd0; cfg_ports = 5'b01000; cfg_trap = 0; cfg_maxlen = 14'd1500;
    cfg_gated = 0;
    frame(MA, 100, 0, 64, 0); cfg_we = 0;
    chk("R11 same-cycle write old", out_hit, 0);
    frame(MA, 100, 0, 64, 0);
    chk("R11 back-to-back valid", out_valid, 1);
    chk("R11 write visible", out_ports, 8);
    idle(); chk("R11 idle", out_valid, 0);

    repeat (2) idle();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule